// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into characters. A free-running enable pulse at sixteen times the bit rate paces it. The line passes through a two-stage synchroniser. A falling edge then starts a qualification window. Only a start bit that stays low through that window leads to data collection. Each later bit is taken once, at the middle of its bit time, least significant bit first. Collection runs through the programmed number of data bits, an optional parity bit and one stop bit.

A finished character goes into a holding register and raises a ready flag. The parity and framing results are captured with the character. The consumer pulses a one-cycle read strobe to take the character. If a second character finishes before the first is read, the first character is kept and an overrun flag is raised. A synchronous mode treats each enable pulse as one whole bit time. A stop bit that reads low after a non-zero character can be reused as the lead-in to a new start bit.

Top module: `serial_char_rx`

## Requirements
- R1: While `rx_en` is low, the receiver does not search for a start bit and does not receive anything, so `rx_ready` stays low.
- R2: In asynchronous mode (`sync_mode`=0), a falling edge on the synchronised line is sampled on the next 8 `tick` pulses. If the line reads high at any of these samples, the start is dropped and the search begins again.
- R3: In synchronous mode (`sync_mode`=1), each `tick` is one bit time. The start bit is checked once, on the first tick after the edge, and every later bit is sampled on the tick after it is presented.
- R4: `char_len` selects 5+`char_len` data bits (0→5, 1→6, 2→7, 3→8). The bits are assembled least significant bit first, each sampled 16 ticks after the previous one, with the start-bit centre set by the eighth qualification sample.
- R5: For characters shorter than 8 bits, the unused upper bits of `rx_data` read as zero.
- R6: `par_mode` selects the parity: 00 none, 01 even, 10 odd, 11 none. With parity on, one parity bit follows the data. `rx_par_err` is loaded with the character and is 1 exactly when the received parity bit does not match the selected parity.
- R7: `rx_frm_err` is loaded with the character and is 1 exactly when the stop bit is sampled low.
- R8: If the stop bit is low, the character is non-zero, and the line then stays low for 8 more ticks, the receiver treats this as a detected start. It qualifies the following bit time as a start bit and receives the next character from it.
- R9: A framing error on an all-zero character does not trigger the restart of R8. A line that then stays low produces no further character until it has gone high and fallen again.
- R10: A loaded character sets `rx_ready`. A one-cycle `rd_strobe` clears `rx_ready` and `rx_overrun`.
- R11: If a character completes while `rx_ready` is set and no read is strobed, `rx_overrun` is set and `rx_data` and its flags keep the older character.
- R12: If a character completes in the same cycle as `rd_strobe`, the new character is loaded, `rx_ready` stays set, and `rx_overrun` stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable: one pulse per 1/16 bit time (one per bit time in synchronous mode) |
| rx_en | input | 1 | Receiver enable |
| sync_mode | input | 1 | 1 selects synchronous timing |
| char_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | Parity select: 00 none, 01 even, 10 odd, 11 none |
| rxd | input | 1 | Serial input line, idle high |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_data | output | 8 | Holding register, right-aligned, upper bits zero |
| rx_ready | output | 1 | A character is waiting |
| rx_par_err | output | 1 | Parity mismatch on the held character |
| rx_frm_err | output | 1 | Low stop bit on the held character |
| rx_overrun | output | 1 | A character was lost while ready was set |

## Verification
Two events can fall in the same clock: a character finishing its stop sample, and the consumer strobing a read. The bench counts ticks from the start edge so that it raises `rd_strobe` exactly on the tick where the stop bit is sampled. The unread earlier character must then be replaced by the new one, with ready still set and no overrun. The same frame sent without a read must instead raise overrun and keep the old data.

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
  parameter int OVS  = 16,
  parameter int QUAL = OVS / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_en,
  input  logic       sync_mode,
  input  logic [1:0] char_len,
  input  logic [1:0] par_mode,
  input  logic       rxd,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       rx_par_err,
  output logic       rx_frm_err,
  output logic       rx_overrun
);
  localparam int CW = $clog2(OVS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;
  st_t st;

  logic [1:0]    sq;
  logic          line, line_d, fall;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx, last_idx;
  logic [7:0]    sh, aligned;
  logic          par_bit, par_on, par_exp;
  logic          bit_tick, qual_done, stop_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sq     <= 2'b11;
      line_d <= 1'b1;
    end else begin
      sq     <= {sq[0], rxd};
      line_d <= sq[1];
    end

  assign line      = sq[1];
  assign fall      = line_d & ~line;
  assign last_idx  = {1'b1, char_len};
  assign bit_tick  = tick & (sync_mode | (cnt == CW'(OVS - 1)));
  assign qual_done = sync_mode | (cnt == CW'(QUAL - 1));
  assign aligned   = sh >> (3'd3 - {1'b0, char_len});
  assign par_on    = (par_mode == 2'b01) | (par_mode == 2'b10);
  assign par_exp   = (par_mode == 2'b10) ? ~^aligned : ^aligned;
  assign stop_hit  = (st == S_STOP) & bit_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sh      <= '0;
      par_bit <= 1'b0;
    end else if (!rx_en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (fall) begin
            st   <= S_START;
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
          end
        S_START:
          if (tick) begin
            if (line) st <= S_IDLE;
            else if (qual_done) begin
              st  <= S_DATA;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
        S_DATA:
          if (bit_tick) begin
            sh  <= {line, sh[7:1]};
            cnt <= '0;
            if (bidx == last_idx) st <= par_on ? S_PAR : S_STOP;
            else bidx <= bidx + 1'b1;
          end else if (tick) cnt <= cnt + 1'b1;
        S_PAR:
          if (bit_tick) begin
            par_bit <= line;
            cnt     <= '0;
            st      <= S_STOP;
          end else if (tick) cnt <= cnt + 1'b1;
        S_STOP:
          if (bit_tick) begin
            cnt  <= '0;
            bidx <= '0;
            if (line || aligned == 8'd0) st <= S_IDLE;
            else if (sync_mode) begin
              st <= S_START;
              sh <= '0;
            end else st <= S_HOLD;
          end else if (tick) cnt <= cnt + 1'b1;
        S_HOLD:
          if (tick) begin
            if (line) st <= S_IDLE;
            else if (cnt == CW'(QUAL - 1)) begin
              st   <= S_START;
              cnt  <= '0;
              bidx <= '0;
              sh   <= '0;
            end else cnt <= cnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      rx_overrun <= 1'b0;
    end else if (stop_hit) begin
      if (rx_ready && !rd_strobe) rx_overrun <= 1'b1;
      else begin
        rx_data    <= aligned;
        rx_ready   <= 1'b1;
        rx_par_err <= par_on & (par_bit != par_exp);
        rx_frm_err <= ~line;
        rx_overrun <= 1'b0;
      end
    end else if (rd_strobe) begin
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
    end

  assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> st == S_IDLE);

  assert_start_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && st == S_START && tick && line) |=> st == S_IDLE);

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_ready) && $stable(char_len)) |-> (rx_data >> (4'd5 + {2'b00, char_len})) == 8'd0);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !stop_hit) |=> !rx_ready && !rx_overrun);

  assert_keep_old_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rd_strobe) |=> $stable(rx_data) && $stable(rx_frm_err) && $stable(rx_par_err));

  assert_same_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && rd_strobe) |=> rx_ready && !rx_overrun);
endmodule

// File: tb/tb_serial_char_rx.sv
module tb_serial_char_rx;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx_en = 1'b1, sync_mode = 1'b0;
  logic [1:0] char_len = 2'd3, par_mode = 2'd0;
  logic rxd = 1'b1, rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic rx_ready, rx_par_err, rx_frm_err, rx_overrun;

  int nvec = 0, nbad = 0, div = 0;
  bit finished = 0;
  logic [7:0] cap_data;
  logic cap_frm;

  serial_char_rx dut (.clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en),
    .sync_mode(sync_mode), .char_len(char_len), .par_mode(par_mode), .rxd(rxd),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_overrun(rx_overrun));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    div  = (div == 3) ? 0 : div + 1;
    tick = (div == 0);
  endtask

  task automatic tick_next();
    do step(); while (!tick);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
  endtask

  // rd_at: 0 none, 1 read while presenting data bit 1, 2 read on the stop-sample tick
  task automatic send(input logic [7:0] d, input int nb, input int pm, input bit bad_par,
                      input bit bad_stop, input int bt, input int rd_at);
    logic [7:0] m;
    logic p;
    m = d & 8'((1 << nb) - 1);
    tick_next(); rxd = 1'b0;
    repeat (bt - 1) tick_next();
    for (int i = 0; i < nb; i++) begin
      tick_next(); rxd = m[i];
      if (rd_at == 1 && i == 1) begin
        cap_data = rx_data;
        cap_frm  = rx_frm_err;
        do_read();
      end
      repeat (bt - 1) tick_next();
    end
    if (pm == 1 || pm == 2) begin
      p = (pm == 2) ? ~^m : ^m;
      tick_next(); rxd = p ^ bad_par;
      repeat (bt - 1) tick_next();
    end
    tick_next(); rxd = ~bad_stop;
    if (rd_at == 2) begin
      repeat (8) tick_next();
      do_read();
      repeat (bt - 9) tick_next();
    end else repeat (bt - 1) tick_next();
  endtask

  task automatic idle_high(input int n);
    tick_next(); rxd = 1'b1;
    repeat (n - 1) tick_next();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nbad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, m;
    bit bp;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(rx_ready == 0 && rx_overrun == 0 && rx_data == 0, "R10 reset", rx_ready, 0);
    idle_high(4);

    // R4 R5 R6: sweep lengths, parity modes and patterns
    for (int cl = 0; cl < 4; cl++)
      for (int pm = 0; pm < 3; pm++)
        for (int k = 0; k < 8; k++) begin
          char_len = 2'(cl);
          par_mode = 2'(pm);
          m  = 8'((1 << (5 + cl)) - 1);
          d  = (k == 0) ? 8'h00 : (k == 7) ? m : 8'((k * 37 + cl * 11 + pm * 5) & m);
          bp = (pm != 0) && k[0];
          send(d, 5 + cl, pm, bp, 0, 16, 0);
          idle_high(2);
          chk(rx_ready == 1, "R10 ready", rx_ready, 1);
          chk(rx_data == d, "R4 data", rx_data, d);
          chk((rx_data & ~m) == 0, "R5 upper", rx_data, d);
          chk(rx_par_err == bp, "R6 parity", rx_par_err, bp);
          chk(rx_frm_err == 0 && rx_overrun == 0, "R7 flags", rx_frm_err, 0);
          do_read();
          chk(rx_ready == 0, "R10 clear", rx_ready, 0);
        end

    char_len = 2'd3; par_mode = 2'd0;

    // R7 framing error on non-zero, line returns high
    send(8'h81, 8, 0, 0, 1, 16, 0);
    idle_high(24);
    chk(rx_ready == 1 && rx_frm_err == 1 && rx_data == 8'h81, "R7 framing", rx_data, 8'h81);
    do_read();

    // R1 disabled receiver
    rx_en = 1'b0;
    send(8'h55, 8, 0, 0, 0, 16, 0);
    idle_high(4);
    chk(rx_ready == 0, "R1 disabled", rx_ready, 0);
    rx_en = 1'b1;
    idle_high(4);

    // R2 short lows are dropped
    tick_next(); rxd = 1'b0; repeat (2) tick_next();
    idle_high(30);
    chk(rx_ready == 0, "R2 glitch3", rx_ready, 0);
    tick_next(); rxd = 1'b0; repeat (6) tick_next();
    idle_high(30);
    chk(rx_ready == 0, "R2 glitch7", rx_ready, 0);
    send(8'hC3, 8, 0, 0, 0, 16, 0);
    idle_high(2);
    chk(rx_ready == 1 && rx_data == 8'hC3, "R2 recover", rx_data, 8'hC3);
    do_read();

    // R8 restart after low stop on non-zero character
    send(8'h5A, 8, 0, 0, 1, 16, 0);
    send(8'h3C, 8, 0, 0, 0, 16, 1);
    idle_high(2);
    chk(cap_data == 8'h5A && cap_frm == 1, "R8 first", cap_data, 8'h5A);
    chk(rx_ready == 1 && rx_data == 8'h3C && rx_frm_err == 0, "R8 second", rx_data, 8'h3C);
    do_read();

    // R9 zero character with low stop: no restart
    send(8'h00, 8, 0, 0, 1, 16, 0);
    tick_next();
    chk(rx_ready == 1 && rx_frm_err == 1 && rx_data == 0, "R9 zero frame", rx_data, 0);
    do_read();
    repeat (48) tick_next();
    chk(rx_ready == 0, "R9 no restart", rx_ready, 0);
    idle_high(16);
    send(8'hA5, 8, 0, 0, 0, 16, 0);
    idle_high(2);
    chk(rx_ready == 1 && rx_data == 8'hA5, "R9 after high", rx_data, 8'hA5);
    do_read();

    // R11 overrun keeps older character
    send(8'h11, 8, 0, 0, 0, 16, 0);
    idle_high(2);
    send(8'h22, 8, 0, 0, 0, 16, 0);
    idle_high(2);
    chk(rx_overrun == 1 && rx_data == 8'h11 && rx_ready == 1, "R11 overrun", rx_data, 8'h11);
    do_read();
    chk(rx_ready == 0 && rx_overrun == 0, "R10 clear ovr", rx_overrun, 0);

    // R12 completion and read in the same cycle
    send(8'h33, 8, 0, 0, 0, 16, 0);
    idle_high(2);
    send(8'h44, 8, 0, 0, 0, 16, 2);
    idle_high(2);
    chk(rx_ready == 1 && rx_overrun == 0 && rx_data == 8'h44, "R12 same cycle", rx_data, 8'h44);
    do_read();

    // R3 synchronous mode
    sync_mode = 1'b1;
    idle_high(4);
    for (int k = 0; k < 4; k++) begin
      char_len = (k < 2) ? 2'd3 : 2'd1;
      par_mode = 2'd2;
      m = (k < 2) ? 8'hFF : 8'h3F;
      d = 8'((k * 91 + 23) & m);
      send(d, (k < 2) ? 8 : 6, 2, k == 1, 0, 1, 0);
      idle_high(3);
      chk(rx_ready == 1 && rx_data == d, "R3 sync data", rx_data, d);
      chk(rx_par_err == (k == 1), "R3 sync parity", rx_par_err, k == 1);
      do_read();
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule